// File: doc/BRIEF.md
# Time-Out Promoted Priority Arbiter

This block decides which of four requesters may use a single shared memory port. The requesters are the display-refresh DMA channel, the signal-processor core, the local bus bridge and the general-purpose DMA channels. Each requester raises a level request and keeps it high until its transfer finishes. The arbiter answers with a one-hot grant. The grant stays with the winner until the port owner pulses a transfer-complete input.

Every requester has its own wait counter and a programmable 8-bit time-out. A request that waits longer than its time-out without service becomes urgent. Urgent requests always win, and among them the order is fixed: display DMA, then signal processor, then local bus, then general DMA. Requests that are not urgent share the port in round-robin order.

If every time-out is left at zero, a request becomes urgent one cycle after it rises. The arbiter then acts as a plain fixed-priority arbiter. Time-outs are written through a simple select/data/enable port. Address decode, memory signalling and burst control are outside this block.

Top module: `prio_arb`

## Requirements
- R1: While reset is asserted and in the first cycle after it, no grant is asserted. All time-outs reset to zero. The round-robin pointer resets to requester 0.
- R2: At most one grant bit is ever high. A grant is only given to a requester whose request was high in the cycle the arbitration took place.
- R3: A grant stays unchanged until `done_i` is sampled high. On the edge that samples `done_i` high, arbitration runs again, so the next grant is visible in the cycle right after the done cycle.
- R4: A request that stays high and ungranted is promoted to urgent once it has waited more than its time-out T. A request that rises before edge k is urgent from edge k+T+1 onward. With T = 0, it is urgent one cycle after it rises.
- R5: When any requesting input is urgent, the grant goes to an urgent requester, whatever the round-robin pointer holds.
- R6: Among urgent requests, the fixed order is bit 0 (display DMA) first, then bit 1 (signal processor), then bit 2 (local bus), then bit 3 (general DMA).
- R7: When no request is urgent, the search for a winner starts at the round-robin pointer and moves upward with wrap-around. After any grant, the pointer moves to the index just past the requester that was granted.
- R8: A wait counter clears when its request drops, and it stays cleared while that requester holds or receives the grant. While waiting, it counts up to its time-out and then stops there.
- R9: A cycle with `cfg_we_i` high loads `cfg_data_i` into the time-out selected by `cfg_sel_i` (0 to 3, in the order of R6). The new value is used in the comparison from the next cycle on.
- R10: With every time-out at zero, requests that are all pending while the port is busy are served strictly in the order of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 4 | Level requests, bit order as in R6 |
| done_i | input | 1 | Single-cycle pulse ending the current grant |
| cfg_we_i | input | 1 | Time-out write enable |
| cfg_sel_i | input | 2 | Index of the time-out to write |
| cfg_data_i | input | 8 | New time-out value |
| gnt_o | output | 4 | One-hot grant, held until done |

## Verification
Two things can happen on the same edge: the done pulse that reopens arbitration, and a requester crossing its time-out or having its wait counter cleared. One test keeps the port busy long enough for the local bus request to be promoted before done arrives, so the promoted request must win over the round-robin pointer. Another test drops and re-raises that request a few cycles before done, so it must lose to the round-robin pointer instead. A scoreboard holds the grant order that the requirements predict for each scenario and compares it with every new grant.

// File: rtl/prio_arb_pkg.sv
`timescale 1ns/1ps
package prio_arb_pkg;
   // requester indices; the order is also the urgent-queue priority
   typedef enum int {
      SRC_DISP_DMA = 0,
      SRC_SIG_CORE = 1,
      SRC_LOC_BUS  = 2,
      SRC_GEN_DMA  = 3
   } src_e;
   localparam int SRC_COUNT   = 4;
   localparam int TMO_W_DEF   = 8;
endpackage

// File: rtl/prio_arb_tmo_regs.sv
`timescale 1ns/1ps
module prio_arb_tmo_regs #(
   parameter int N_REQ = 4,
   parameter int TMO_W = 8,
   localparam int SEL_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        we_i,
   input  logic [SEL_W-1:0]            sel_i,
   input  logic [TMO_W-1:0]            data_i,
   output logic [N_REQ-1:0][TMO_W-1:0] tmo_o
);
   for (genvar g = 0; g < N_REQ; g++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)
            tmo_o[g] <= '0;
         else if (we_i && (sel_i == SEL_W'(g)))
            tmo_o[g] <= data_i;
      end
   end
endmodule

// File: rtl/prio_arb_ager.sv
`timescale 1ns/1ps
module prio_arb_ager #(
   parameter int TMO_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic             own_i,   // granted next cycle or still holding
   input  logic [TMO_W-1:0] tmo_i,
   output logic             urg_o
);
   logic [TMO_W-1:0] wait_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wait_q <= '0;
         urg_o  <= 1'b0;
      end else if (!req_i || own_i) begin
         wait_q <= '0;
         urg_o  <= 1'b0;
      end else begin
         urg_o <= (wait_q >= tmo_i);
         if (wait_q < tmo_i)
            wait_q <= wait_q + 1'b1;
      end
   end
endmodule

// File: rtl/prio_arb_pick.sv
`timescale 1ns/1ps
module prio_arb_pick #(
   parameter int N_REQ     = 4,
   parameter bit FAIR_POOL = 1'b1,
   localparam int SEL_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
   input  logic [N_REQ-1:0] req_i,
   input  logic [N_REQ-1:0] urg_i,
   input  logic [SEL_W-1:0] ptr_i,
   output logic [N_REQ-1:0] pick_o
);
   logic [N_REQ-1:0] hot;
   logic [N_REQ-1:0] hot_pick;
   logic [N_REQ-1:0] pool_pick;

   assign hot = req_i & urg_i;

   always_comb begin
      hot_pick = '0;
      for (int k = N_REQ - 1; k >= 0; k--)
         if (hot[k]) hot_pick = N_REQ'(1) << k;
   end

   if (FAIR_POOL) begin : g_rr
      always_comb begin
         automatic int  idx;
         automatic logic seen;
         pool_pick = '0;
         seen      = 1'b0;
         for (int k = 0; k < N_REQ; k++) begin
            idx = int'(ptr_i) + k;
            if (idx >= N_REQ) idx = idx - N_REQ;
            if (!seen && req_i[idx]) begin
               pool_pick[idx] = 1'b1;
               seen = 1'b1;
            end
         end
      end
   end else begin : g_fixed
      logic [SEL_W-1:0] unused_ptr;
      assign unused_ptr = ptr_i;
      always_comb begin
         pool_pick = '0;
         for (int k = N_REQ - 1; k >= 0; k--)
            if (req_i[k]) pool_pick = N_REQ'(1) << k;
      end
   end

   assign pick_o = (|hot) ? hot_pick : pool_pick;
endmodule

// File: rtl/prio_arb.sv
`timescale 1ns/1ps
module prio_arb
   import prio_arb_pkg::*;
#(
   parameter int N_REQ     = SRC_COUNT,
   parameter int TMO_W     = TMO_W_DEF,
   parameter bit FAIR_POOL = 1'b1,
   localparam int SEL_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_REQ-1:0] req_i,
   input  logic             done_i,
   input  logic             cfg_we_i,
   input  logic [SEL_W-1:0] cfg_sel_i,
   input  logic [TMO_W-1:0] cfg_data_i,
   output logic [N_REQ-1:0] gnt_o
);
   if (N_REQ < 2) begin : g_bad_n
      $error("prio_arb: N_REQ must be at least 2");
   end
   if (TMO_W < 1) begin : g_bad_w
      $error("prio_arb: TMO_W must be at least 1");
   end

   logic [N_REQ-1:0][TMO_W-1:0] tmo;
   logic [N_REQ-1:0]            urg_vec;
   logic [N_REQ-1:0]            pick;
   logic [N_REQ-1:0]            gnt_q;
   logic [N_REQ-1:0]            gnt_d;
   logic [SEL_W-1:0]            ptr_q;
   logic [SEL_W-1:0]            win_idx;
   logic                        arb_en;

   prio_arb_tmo_regs #(.N_REQ(N_REQ), .TMO_W(TMO_W)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .we_i  (cfg_we_i),
      .sel_i (cfg_sel_i),
      .data_i(cfg_data_i),
      .tmo_o (tmo)
   );

   for (genvar g = 0; g < N_REQ; g++) begin : g_age
      prio_arb_ager #(.TMO_W(TMO_W)) u_ager (
         .clk  (clk),
         .rst_n(rst_n),
         .req_i(req_i[g]),
         .own_i(gnt_d[g]),
         .tmo_i(tmo[g]),
         .urg_o(urg_vec[g])
      );
   end

   prio_arb_pick #(.N_REQ(N_REQ), .FAIR_POOL(FAIR_POOL)) u_pick (
      .req_i (req_i),
      .urg_i (urg_vec),
      .ptr_i (ptr_q),
      .pick_o(pick)
   );

   assign arb_en = !(|gnt_q) || done_i;
   assign gnt_d  = arb_en ? pick : gnt_q;

   always_comb begin
      win_idx = '0;
      for (int k = 0; k < N_REQ; k++)
         if (pick[k]) win_idx = SEL_W'(k);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gnt_q <= '0;
         ptr_q <= '0;
      end else begin
         gnt_q <= gnt_d;
         if (arb_en && (|pick))
            ptr_q <= (win_idx == SEL_W'(N_REQ - 1)) ? '0 : win_idx + 1'b1;
      end
   end

   assign gnt_o = gnt_q;
endmodule

// File: rtl/prio_arb_chk.sv
`timescale 1ns/1ps
module prio_arb_chk #(
   parameter int N_REQ = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_REQ-1:0] req_i,
   input logic             done_i,
   input logic [N_REQ-1:0] gnt_o,
   input logic [N_REQ-1:0] urg_i,
   input logic             arb_en_i
);
   a_r2_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_o));

   a_r2_grant_to_requester: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_o != '0 && gnt_o != $past(gnt_o)) |-> ((gnt_o & $past(req_i)) == gnt_o));

   a_r3_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(gnt_o) != '0 && !$past(done_i)) |-> (gnt_o == $past(gnt_o)));

   a_r5_urgent_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(arb_en_i) && ($past(urg_i & req_i) != '0))
         |-> ((gnt_o & $past(urg_i & req_i)) != '0));

   a_r6_urgent_order: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(arb_en_i) && ($past(urg_i & req_i) != '0))
         |-> (gnt_o == ($past(urg_i & req_i) & (~$past(urg_i & req_i) + 1'b1))));
endmodule

bind prio_arb prio_arb_chk #(.N_REQ(N_REQ)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .req_i   (req_i),
   .done_i  (done_i),
   .gnt_o   (gnt_o),
   .urg_i   (urg_vec),
   .arb_en_i(arb_en)
);

// File: tb/prio_arb_test.sv
`timescale 1ns/1ps
module prio_arb_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] req = '0;
   logic       done = 1'b0;
   logic       cfg_we = 1'b0;
   logic [1:0] cfg_sel = '0;
   logic [7:0] cfg_data = '0;
   logic [3:0] gnt_o;

   int n_checks = 0;
   int n_fail   = 0;
   int hold_len = 1;
   bit reported = 0;
   int    exp_q[$];
   string tag_q[$];

   always #5 clk = ~clk;

   prio_arb uut (
      .clk(clk), .rst_n(rst_n), .req_i(req), .done_i(done),
      .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_data_i(cfg_data),
      .gnt_o(gnt_o)
   );

   task automatic report();
      if (!reported) begin
         reported = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   task automatic check(bit ok, string tag, int act, int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic expect_grant(int idx, string tag);
      exp_q.push_back(idx);
      tag_q.push_back(tag);
   endtask

   task automatic cfg_write(int sel, int val);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_data = 8'(val);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic wait_idle();
      do @(negedge clk); while (!(req == '0 && gnt_o == '0));
      repeat (2) @(negedge clk);
   endtask

   task automatic wait_grant(logic [3:0] m);
      do @(negedge clk); while (gnt_o != m);
   endtask

   // monitor and responder: compares each new grant, pulses done after hold_len cycles
   initial begin : monitor
      logic [3:0] prev;
      bit         done_was;
      int         hc;
      prev = '0;
      hc   = 0;
      @(posedge rst_n);
      forever begin
         @(negedge clk);
         done_was = done;
         if (gnt_o != prev) begin
            if (prev != '0)
               check(done_was, "R3 grant changed without done", int'(gnt_o), int'(prev));
            if (gnt_o != '0) begin
               hc = 0;
               if (exp_q.size() == 0)
                  check(1'b0, "R2 unexpected grant", int'(gnt_o), 0);
               else begin
                  automatic int    e = exp_q.pop_front();
                  automatic string t = tag_q.pop_front();
                  check(gnt_o == (4'b1 << e), t, int'(gnt_o), int'(4'b1 << e));
               end
            end
         end else if (prev != '0 && !done_was) begin
            check(1'b1, "R3 hold", int'(gnt_o), int'(prev));
         end
         if (done)
            done = 1'b0;
         else if (gnt_o != '0) begin
            if (hc >= hold_len - 1) begin
               done = 1'b1;
               req  = req & ~gnt_o;
               hc   = 0;
            end else
               hc++;
         end
         prev = gnt_o;
      end
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin : driver
      repeat (3) @(negedge clk);
      check(gnt_o == '0, "R1 grant low in reset", int'(gnt_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(gnt_o == '0, "R1 grant low after reset", int'(gnt_o), 0);

      // R10/R4: time-outs at reset value zero; pointer moves to 2 first
      expect_grant(1, "R7 lone request");
      req = 4'b0010;
      wait_idle();
      expect_grant(2, "R7 pointer start");
      expect_grant(0, "R10 zero time-out order first");
      expect_grant(1, "R10 zero time-out order second");
      expect_grant(3, "R10 zero time-out order last");
      req = 4'b1111;
      wait_idle();

      // R7/R9: long time-outs give plain round robin
      for (int i = 0; i < 4; i++) cfg_write(i, 200);
      expect_grant(2, "R7 lone request");
      req = 4'b0100;
      wait_idle();
      expect_grant(3, "R7 rotation 3");
      expect_grant(0, "R7 rotation 0");
      expect_grant(1, "R7 rotation 1");
      expect_grant(2, "R7 rotation 2");
      req = 4'b1111;
      wait_idle();

      // R5/R4: local bus promoted during a long grant beats the pointer
      cfg_write(2, 3);
      hold_len = 10;
      expect_grant(0, "R3 long holder");
      req = 4'b0001;
      wait_grant(4'b0001);
      req = req | 4'b1110;
      expect_grant(2, "R5 promoted wins");
      expect_grant(3, "R7 after promotion");
      expect_grant(1, "R7 last");
      wait_idle();

      // R6: several urgent at once, fixed order regardless of pointer
      for (int i = 0; i < 4; i++) cfg_write(i, 2);
      expect_grant(1, "R3 long holder");
      req = 4'b0010;
      wait_grant(4'b0010);
      req = req | 4'b1101;
      expect_grant(0, "R6 urgent first");
      expect_grant(2, "R6 urgent second");
      expect_grant(3, "R6 urgent third");
      wait_idle();

      // R8: dropping a request clears its wait, so it loses to the pointer
      cfg_write(0, 200); cfg_write(1, 200); cfg_write(2, 5); cfg_write(3, 200);
      hold_len = 20;
      expect_grant(0, "R3 long holder");
      req = 4'b0001;
      wait_grant(4'b0001);
      req = req | 4'b0110;
      repeat (15) @(negedge clk);
      req[2] = 1'b0;
      @(negedge clk);
      req[2] = 1'b1;
      expect_grant(1, "R8 cleared wait loses");
      expect_grant(2, "R8 served after");
      wait_idle();
      hold_len = 1;

      check(exp_q.size() == 0, "R2 all expected grants seen", exp_q.size(), 0);
      report();
   end
endmodule